// File: doc/BRIEF.md
# Coalesced Translation Response Distributor

This block sits below an address-translation coalescer. A coalescer merges several translation requests that fall in the same 4 KiB virtual page into one group and sends a single lookup downstream. While that lookup is in flight, each member of the group is recorded here. Every member keeps its full virtual address, the requester port it arrived on, and a prefetch marker. The group is filed under its virtual page number.

When the translation comes back, the block finds the group by virtual page. It then emits one response per member, one per cycle, in the order the members were recorded. Only the first member was actually translated. Every later member gets a physical address rebuilt from the returned physical page and its own page offset. The page size is given per translation by a 2-bit code.

All members carry the returned uncacheable flag, entry-valid flag and hit level. A member also reports whether its request-count level must be removed, which applies to non-prefetch members. The group's slot is freed at the clock edge that ends its last response. A pending-page query lets the issue logic see whether a page still has a group outstanding.

Top module: `xlat_resp_distributor`

## Requirements
- R1: After reset, rspReady is 1, outValid is 0, lookupErr is 0, and qryPending is 0 for any address.
- R2: An insert files the member under page insVaddr[VA_W-1:12]. It joins an existing group for that page, or otherwise takes the lowest free slot. qryPending for that page is 1 from the next cycle. Members beyond MEMBERS in one group are ignored.
- R3: rspSizeCode selects the page size: 0 is 4 KiB, 1 is 64 KiB, 2 is 2 MiB, and 3 is treated as 4 KiB.
- R4: The first member's outPaddr equals rspPaddr unchanged.
- R5: A later member's outPaddr is rspPaddr with its low page bits cleared, ORed with that member's virtual address masked by page size minus one.
- R6: Every member's response carries the accepted rspUncache, rspEntryValid and rspHitLevel values.
- R7: Each response's outPort is the insPort recorded for that member.
- R8: outPopLevel is 1 exactly for members inserted with insPrefetch 0.
- R9: After a response is accepted with a hit, the members appear on consecutive cycles in insertion order, starting the cycle after acceptance. rspReady stays 0 from the first member through the last member.
- R10: qryPending for the page is still 1 in the cycle of the last member. It is 0 from the next cycle, when rspReady returns to 1 and the slot can be allocated again.
- R11: A response whose page has no group raises lookupErr for exactly one cycle after acceptance. It produces no member responses and leaves rspReady at 1.
- R12: An insert for a new page while all SLOTS slots are in use is ignored. Its page does not become pending, and a later response for it is reported as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Record one group member this cycle |
| insVaddr | input | VA_W | Member virtual address |
| insPort | input | PORT_W | Requester port of the member |
| insPrefetch | input | 1 | Member is a prefetch |
| qryVaddr | input | VA_W | Address whose page is queried |
| qryPending | output | 1 | Queried page has an outstanding group |
| rspValid | input | 1 | Completed translation offered |
| rspReady | output | 1 | Completed translation can be taken |
| rspVaddr | input | VA_W | Virtual address of the translated request |
| rspPaddr | input | PA_W | Returned physical address |
| rspSizeCode | input | 2 | Page size code |
| rspUncache | input | 1 | Translation is uncacheable |
| rspEntryValid | input | 1 | Returned entry valid flag |
| rspHitLevel | input | HIT_W | Level where the lookup hit |
| outValid | output | 1 | A member response is presented |
| outPort | output | PORT_W | Port the response returns to |
| outPaddr | output | PA_W | Rebuilt physical address |
| outUncache | output | 1 | Uncacheable attribute |
| outEntryValid | output | 1 | Entry valid flag |
| outHitLevel | output | HIT_W | Hit level |
| outPopLevel | output | 1 | Remove the member's request-count level |
| lookupErr | output | 1 | Response had no outstanding group |

## Verification
The assertions check the following on every cycle:
- a member stream only starts after a response was accepted;
- the member index steps by one across consecutive responses;
- a lookup error only follows a missed acceptance;
- a released slot is invalid on the next edge;
- no group count exceeds its capacity;
- every response keeps the returned physical page bits.

The bench scenarios show the rest:
- the offset merge under each page-size code;
- per-member port and prefetch routing;
- the exact cycle in which the pending query drops;
- the capacity limits on members and on slots.

// File: rtl/xlat_dist_pkg.sv
package xlat_dist_pkg;

  localparam int unsigned PAGE_BASE_SHIFT = 12;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_64K  = 2'd1,
    PG_2M   = 2'd2,
    PG_RSVD = 2'd3
  } pageCode_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } ctrlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic doLatch;
    logic doEmit;
    logic doRelease;
  } distStrobe_t;

  function automatic int unsigned pageShift(input logic [1:0] code);
    case (code)
      PG_64K:  return 16;
      PG_2M:   return 21;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/xlat_dist_datapath.sv
module xlat_dist_datapath
  import xlat_dist_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 40,
  parameter int NUM_PORTS = 4,
  parameter int HIT_W     = 2,
  parameter int SLOTS     = 4,
  parameter int MEMBERS   = 4,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IDX_W    = (MEMBERS > 1) ? $clog2(MEMBERS) : 1,
  localparam int CNT_W    = $clog2(MEMBERS + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [VA_W-1:0]   insVaddr,
  input  logic [PORT_W-1:0] insPort,
  input  logic              insPrefetch,
  input  logic [VA_W-1:0]   qryVaddr,
  output logic              qryPending,
  input  logic [VA_W-1:0]   rspVaddr,
  input  logic [PA_W-1:0]   rspPaddr,
  input  logic [1:0]        rspSizeCode,
  input  logic              rspUncache,
  input  logic              rspEntryValid,
  input  logic [HIT_W-1:0]  rspHitLevel,
  output logic              lookupHit,
  output logic [CNT_W-1:0]  groupCnt,
  input  distStrobe_t       strb,
  input  logic [IDX_W-1:0]  memberIdx,
  output logic              outValid,
  output logic [PORT_W-1:0] outPort,
  output logic [PA_W-1:0]   outPaddr,
  output logic              outUncache,
  output logic              outEntryValid,
  output logic [HIT_W-1:0]  outHitLevel,
  output logic              outPopLevel
);

  localparam int VPN_W  = VA_W - PAGE_BASE_SHIFT;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // Outstanding group table
  logic [SLOTS-1:0]  slotValid;
  logic [VPN_W-1:0]  slotVpn  [SLOTS];
  logic [CNT_W-1:0]  slotCnt  [SLOTS];
  logic [VA_W-1:0]   memVa    [SLOTS][MEMBERS];
  logic [PORT_W-1:0] memPort  [SLOTS][MEMBERS];
  logic              memPf    [SLOTS][MEMBERS];

  // Translation captured at acceptance
  logic [SLOT_W-1:0] lSlot;
  logic [PA_W-1:0]   lPaddr;
  logic [1:0]        lCode;
  logic              lUnc;
  logic              lEntValid;
  logic [HIT_W-1:0]  lHit;

  logic [VPN_W-1:0] insVpn, rspVpn, qryVpn;
  assign insVpn = insVaddr[VA_W-1:PAGE_BASE_SHIFT];
  assign rspVpn = rspVaddr[VA_W-1:PAGE_BASE_SHIFT];
  assign qryVpn = qryVaddr[VA_W-1:PAGE_BASE_SHIFT];

  logic [SLOTS-1:0] insHitV, rspHitV, qryHitV;

  for (genvar s = 0; s < SLOTS; s++) begin : gMatch
    assign insHitV[s] = slotValid[s] && (slotVpn[s] == insVpn);
    assign rspHitV[s] = slotValid[s] && (slotVpn[s] == rspVpn);
    assign qryHitV[s] = slotValid[s] && (slotVpn[s] == qryVpn);
  end

  assign lookupHit  = |rspHitV;
  assign qryPending = |qryHitV;

  // Lowest-index encoders
  logic [SLOT_W-1:0] rspSlot, matchSlot, freeSlot;
  always_comb begin
    rspSlot   = '0;
    matchSlot = '0;
    freeSlot  = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (rspHitV[s])    rspSlot   = SLOT_W'(s);
      if (insHitV[s])    matchSlot = SLOT_W'(s);
      if (!slotValid[s]) freeSlot  = SLOT_W'(s);
    end
  end

  logic              insJoin, insRoom, insDo;
  logic [SLOT_W-1:0] insSlot;
  logic [IDX_W-1:0]  insIdx;
  always_comb begin
    insJoin = |insHitV;
    insSlot = insJoin ? matchSlot : freeSlot;
    if (insJoin) insRoom = slotCnt[matchSlot] < CNT_W'(MEMBERS);
    else         insRoom = ~&slotValid;
    insIdx = insJoin ? IDX_W'(slotCnt[matchSlot]) : '0;
    insDo  = insValid && insRoom;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        slotVpn[s] <= '0;
        slotCnt[s] <= '0;
      end
    end else begin
      if (insDo) begin
        if (insJoin) begin
          slotCnt[insSlot] <= slotCnt[insSlot] + CNT_W'(1);
        end else begin
          slotValid[insSlot] <= 1'b1;
          slotVpn[insSlot]   <= insVpn;
          slotCnt[insSlot]   <= CNT_W'(1);
        end
      end
      if (strb.doRelease) slotValid[lSlot] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (insDo) begin
      memVa[insSlot][insIdx]   <= insVaddr;
      memPort[insSlot][insIdx] <= insPort;
      memPf[insSlot][insIdx]   <= insPrefetch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lSlot     <= '0;
      lPaddr    <= '0;
      lCode     <= '0;
      lUnc      <= 1'b0;
      lEntValid <= 1'b0;
      lHit      <= '0;
    end else if (strb.doLatch) begin
      lSlot     <= rspSlot;
      lPaddr    <= rspPaddr;
      lCode     <= rspSizeCode;
      lUnc      <= rspUncache;
      lEntValid <= rspEntryValid;
      lHit      <= rspHitLevel;
    end
  end

  assign groupCnt = slotCnt[lSlot];

  // Physical address rebuild
  logic [PA_W-1:0] pageMask, vaExt;
  always_comb begin
    pageMask = (PA_W'(1) << pageShift(lCode)) - PA_W'(1);
    vaExt    = PA_W'(memVa[lSlot][memberIdx]);
    if (memberIdx == '0) outPaddr = lPaddr;
    else                 outPaddr = (lPaddr & ~pageMask) | (vaExt & pageMask);
  end

  assign outValid      = strb.doEmit;
  assign outPort       = memPort[lSlot][memberIdx];
  assign outPopLevel   = !memPf[lSlot][memberIdx];
  assign outUncache    = lUnc;
  assign outEntryValid = lEntValid;
  assign outHitLevel   = lHit;

  assert_release_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.doRelease |=> !slotValid[$past(lSlot)]);

  for (genvar s = 0; s < SLOTS; s++) begin : gCntChk
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
      slotCnt[s] <= CNT_W'(MEMBERS));
  end

  assert_page_base_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (((outPaddr ^ lPaddr) & ~pageMask) == '0));

endmodule

// File: rtl/xlat_dist_ctrl.sv
module xlat_dist_ctrl
  import xlat_dist_pkg::*;
#(
  parameter int MEMBERS = 4,
  localparam int IDX_W  = (MEMBERS > 1) ? $clog2(MEMBERS) : 1,
  localparam int CNT_W  = $clog2(MEMBERS + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rspValid,
  output logic             rspReady,
  input  logic             lookupHit,
  input  logic [CNT_W-1:0] groupCnt,
  output distStrobe_t      strb,
  output logic [IDX_W-1:0] memberIdx,
  output logic             lookupErr
);

  ctrlState_e state;
  logic       accept, lastMember;

  always_comb begin
    rspReady       = (state == ST_IDLE);
    accept         = rspValid && rspReady;
    lastMember     = (CNT_W'(memberIdx) + CNT_W'(1)) == groupCnt;
    strb.doLatch   = accept && lookupHit;
    strb.doEmit    = (state == ST_DRAIN);
    strb.doRelease = strb.doEmit && lastMember;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      memberIdx <= '0;
      lookupErr <= 1'b0;
    end else begin
      lookupErr <= accept && !lookupHit;
      case (state)
        ST_IDLE: if (strb.doLatch) begin
          state     <= ST_DRAIN;
          memberIdx <= '0;
        end
        ST_DRAIN: begin
          if (strb.doRelease) state <= ST_IDLE;
          else memberIdx <= memberIdx + IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_start_after_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.doEmit) |-> $past(rspValid && rspReady && lookupHit));

  assert_index_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doEmit && $past(strb.doEmit)) |-> memberIdx == $past(memberIdx) + IDX_W'(1));

  assert_err_after_miss_R11: assert property (@(posedge clk) disable iff (!rstN)
    lookupErr |-> $past(rspValid && rspReady && !lookupHit));

endmodule

// File: rtl/xlat_resp_distributor.sv
module xlat_resp_distributor
  import xlat_dist_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 40,
  parameter int NUM_PORTS = 4,
  parameter int HIT_W     = 2,
  parameter int SLOTS     = 4,
  parameter int MEMBERS   = 4,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IDX_W    = (MEMBERS > 1) ? $clog2(MEMBERS) : 1,
  localparam int CNT_W    = $clog2(MEMBERS + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [VA_W-1:0]   insVaddr,
  input  logic [PORT_W-1:0] insPort,
  input  logic              insPrefetch,
  input  logic [VA_W-1:0]   qryVaddr,
  output logic              qryPending,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [VA_W-1:0]   rspVaddr,
  input  logic [PA_W-1:0]   rspPaddr,
  input  logic [1:0]        rspSizeCode,
  input  logic              rspUncache,
  input  logic              rspEntryValid,
  input  logic [HIT_W-1:0]  rspHitLevel,
  output logic              outValid,
  output logic [PORT_W-1:0] outPort,
  output logic [PA_W-1:0]   outPaddr,
  output logic              outUncache,
  output logic              outEntryValid,
  output logic [HIT_W-1:0]  outHitLevel,
  output logic              outPopLevel,
  output logic              lookupErr
);

  distStrobe_t      strb;
  logic             lookupHit;
  logic [CNT_W-1:0] groupCnt;
  logic [IDX_W-1:0] memberIdx;

  xlat_dist_ctrl #(.MEMBERS(MEMBERS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rspValid  (rspValid),
    .rspReady  (rspReady),
    .lookupHit (lookupHit),
    .groupCnt  (groupCnt),
    .strb      (strb),
    .memberIdx (memberIdx),
    .lookupErr (lookupErr)
  );

  xlat_dist_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .NUM_PORTS(NUM_PORTS),
    .HIT_W(HIT_W), .SLOTS(SLOTS), .MEMBERS(MEMBERS)
  ) uPath (
    .clk           (clk),
    .rstN          (rstN),
    .insValid      (insValid),
    .insVaddr      (insVaddr),
    .insPort       (insPort),
    .insPrefetch   (insPrefetch),
    .qryVaddr      (qryVaddr),
    .qryPending    (qryPending),
    .rspVaddr      (rspVaddr),
    .rspPaddr      (rspPaddr),
    .rspSizeCode   (rspSizeCode),
    .rspUncache    (rspUncache),
    .rspEntryValid (rspEntryValid),
    .rspHitLevel   (rspHitLevel),
    .lookupHit     (lookupHit),
    .groupCnt      (groupCnt),
    .strb          (strb),
    .memberIdx     (memberIdx),
    .outValid      (outValid),
    .outPort       (outPort),
    .outPaddr      (outPaddr),
    .outUncache    (outUncache),
    .outEntryValid (outEntryValid),
    .outHitLevel   (outHitLevel),
    .outPopLevel   (outPopLevel)
  );

endmodule

// File: tb/xlat_resp_distributor_test.sv
module xlat_resp_distributor_test;

  localparam int VA_W = 32, PA_W = 40, NP = 4, HIT_W = 2, SL = 4, MB = 4;

  logic clk = 0, rstN = 0;
  logic insValid = 0, insPrefetch = 0;
  logic [VA_W-1:0] insVaddr = '0, qryVaddr = '0, rspVaddr = '0;
  logic [1:0] insPort = '0, rspSizeCode = '0;
  logic rspValid = 0, rspUncache = 0, rspEntryValid = 0;
  logic [PA_W-1:0] rspPaddr = '0;
  logic [HIT_W-1:0] rspHitLevel = '0;
  logic qryPending, rspReady, outValid, outUncache, outEntryValid, outPopLevel, lookupErr;
  logic [1:0] outPort;
  logic [PA_W-1:0] outPaddr;
  logic [HIT_W-1:0] outHitLevel;

  xlat_resp_distributor uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;

  function automatic void chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endfunction

  typedef struct packed {
    logic [PA_W-1:0] paddr;
    logic [1:0] port;
    logic unc, ev, pop, first;
    logic [HIT_W-1:0] hit;
  } exp_t;
  exp_t expQ[$];
  exp_t monItem;

  // Bench model of the outstanding table
  bit mValid[SL];
  logic [19:0] mVpn[SL];
  int mCnt[SL];
  logic [VA_W-1:0] mVa[SL][MB];
  logic [1:0] mPort[SL][MB];
  bit mPf[SL][MB];

  task automatic insert(input logic [VA_W-1:0] va, input logic [1:0] port, input bit pf);
    int slot = -1;
    @(negedge clk);
    for (int s = 0; s < SL; s++) if (mValid[s] && mVpn[s] == va[31:12]) slot = s;
    if (slot >= 0) begin
      if (mCnt[slot] < MB) begin
        mVa[slot][mCnt[slot]] = va; mPort[slot][mCnt[slot]] = port; mPf[slot][mCnt[slot]] = pf;
        mCnt[slot]++;
      end
    end else begin
      for (int s = SL - 1; s >= 0; s--) if (!mValid[s]) slot = s;
      if (slot >= 0) begin
        mValid[slot] = 1; mVpn[slot] = va[31:12]; mCnt[slot] = 1;
        mVa[slot][0] = va; mPort[slot][0] = port; mPf[slot][0] = pf;
      end
    end
    insValid = 1; insVaddr = va; insPort = port; insPrefetch = pf;
    @(negedge clk);
    insValid = 0;
  endtask

  task automatic respond(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                         input logic [1:0] code, input bit unc, input bit ev,
                         input logic [HIT_W-1:0] hit);
    int slot = -1;
    int sh;
    logic [63:0] mask;
    exp_t e;
    @(negedge clk);
    while (!rspReady) @(negedge clk);
    sh = (code == 2'd1) ? 16 : (code == 2'd2) ? 21 : 12;
    mask = (64'd1 << sh) - 1;
    for (int s = 0; s < SL; s++) if (mValid[s] && mVpn[s] == va[31:12]) slot = s;
    if (slot >= 0) begin
      for (int m = 0; m < mCnt[slot]; m++) begin
        e.first = (m == 0);
        e.paddr = (m == 0) ? pa : PA_W'((64'(pa) & ~mask) | (64'(mVa[slot][m]) & mask));
        e.port = mPort[slot][m];
        e.unc = unc; e.ev = ev; e.hit = hit; e.pop = !mPf[slot][m];
        expQ.push_back(e);
      end
      mValid[slot] = 0;
    end
    rspValid = 1; rspVaddr = va; rspPaddr = pa; rspSizeCode = code;
    rspUncache = unc; rspEntryValid = ev; rspHitLevel = hit;
    @(negedge clk);
    rspValid = 0;
  endtask

  task automatic waitDrain();
    @(negedge clk);
    while (outValid || !rspReady) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) chk(0, "R9 unexpected response", 64'(outPaddr), 64'd0);
      else begin
        monItem = expQ.pop_front();
        chk(outPaddr == monItem.paddr, monItem.first ? "R4 paddr" : "R5 R3 paddr",
            64'(outPaddr), 64'(monItem.paddr));
        chk(outPort == monItem.port, "R7 port", 64'(outPort), 64'(monItem.port));
        chk(outUncache == monItem.unc, "R6 uncache", 64'(outUncache), 64'(monItem.unc));
        chk(outEntryValid == monItem.ev, "R6 entry valid", 64'(outEntryValid), 64'(monItem.ev));
        chk(outHitLevel == monItem.hit, "R6 hit level", 64'(outHitLevel), 64'(monItem.hit));
        chk(outPopLevel == monItem.pop, "R8 pop level", 64'(outPopLevel), 64'(monItem.pop));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(rspReady == 1, "R1 ready", 64'(rspReady), 64'd1);
    chk(outValid == 0, "R1 outValid", 64'(outValid), 64'd0);
    chk(lookupErr == 0, "R1 lookupErr", 64'(lookupErr), 64'd0);
    qryVaddr = 32'h1234_5000;
    #1 chk(qryPending == 0, "R1 pending", 64'(qryPending), 64'd0);

    // Group of three, 4 KiB, with R9/R10 timing
    insert(32'h1234_5010, 2'd1, 0);
    insert(32'h1234_5abc, 2'd3, 1);
    insert(32'h1234_5ff8, 2'd0, 0);
    chk(qryPending == 1, "R2 pending after insert", 64'(qryPending), 64'd1);
    respond(32'h1234_5010, 40'h98_7654_3010, 2'd0, 1, 1, 2'd2);
    chk(outValid == 1 && rspReady == 0, "R9 first member cycle", {outValid, rspReady}, 64'b10);
    @(negedge clk);
    chk(outValid == 1 && rspReady == 0, "R9 second member cycle", {outValid, rspReady}, 64'b10);
    @(negedge clk);
    chk(qryPending == 1 && outValid == 1, "R10 pending in last cycle", {qryPending, outValid}, 64'b11);
    @(negedge clk);
    chk(qryPending == 0, "R10 pending cleared", 64'(qryPending), 64'd0);
    chk(rspReady == 1 && outValid == 0, "R10 ready back", {rspReady, outValid}, 64'b10);

    // 64 KiB page
    insert(32'h4000_1234, 2'd2, 0);
    insert(32'h4000_1f00, 2'd1, 1);
    respond(32'h4000_1234, 40'h77_0005_1234, 2'd1, 0, 1, 2'd1);
    waitDrain();

    // 2 MiB page
    insert(32'h0a3c_5678, 2'd3, 0);
    insert(32'h0a3c_5004, 2'd2, 0);
    respond(32'h0a3c_5678, 40'h5f_1f25_5678, 2'd2, 1, 0, 2'd3);
    waitDrain();

    // Reserved code acts as 4 KiB
    insert(32'h0777_7100, 2'd0, 1);
    insert(32'h0777_7e2c, 2'd1, 0);
    respond(32'h0777_7100, 40'h12_3456_7100, 2'd3, 0, 1, 2'd0);
    waitDrain();

    // Miss
    respond(32'hdead_b000, 40'h1, 2'd0, 0, 1, 2'd0);
    chk(lookupErr == 1, "R11 error pulse", 64'(lookupErr), 64'd1);
    chk(outValid == 0 && rspReady == 1, "R11 no response", {outValid, rspReady}, 64'b01);
    @(negedge clk);
    chk(lookupErr == 0, "R11 single cycle", 64'(lookupErr), 64'd0);

    // Member overflow: five inserts, four kept
    for (int i = 0; i < 5; i++) insert(32'h2222_2000 + 32'(i * 8), 2'(i), 0);
    respond(32'h2222_2000, 40'h33_3333_3000, 2'd0, 0, 1, 2'd1);
    waitDrain();
    chk(expQ.size() == 0, "R2 member cap", 64'(expQ.size()), 64'd0);

    // Slot capacity
    for (int p = 0; p < 4; p++) insert(32'h5000_0000 + 32'(p << 12), 2'(p), 0);
    insert(32'h6000_0000, 2'd1, 0);
    qryVaddr = 32'h6000_0000;
    #1 chk(qryPending == 0, "R12 full insert ignored", 64'(qryPending), 64'd0);
    respond(32'h6000_0000, 40'h9, 2'd0, 0, 1, 2'd0);
    chk(lookupErr == 1, "R12 full insert misses", 64'(lookupErr), 64'd1);
    for (int p = 0; p < 4; p++) respond(32'h5000_0000 + 32'(p << 12), 40'hab_0000_0000 + 40'(p << 12), 2'd0, 0, 1, 2'(p));
    waitDrain();
    // Slot reuse
    insert(32'h6000_0040, 2'd2, 1);
    chk(qryPending == 1, "R10 slot reusable", 64'(qryPending), 64'd1);
    respond(32'h6000_0040, 40'h01_0000_0040, 2'd0, 1, 1, 2'd2);
    waitDrain();
    chk(expQ.size() == 0, "R9 all responses seen", 64'(expQ.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule